// File: doc/BRIEF.md
# GPIO Bank Restore Sequencer

This block puts a saved configuration back into one GPIO bank without letting any pin glitch on the way. A start pulse arrives with the saved mode, data and pull-up words and a flag for the bank type. The block first reads the bank's live mode and data words over a simple register port. For each pin it then decides whether the new mode must land before or after the data word. Finally it issues the writes in a fixed order and pulses done.

A standard bank has a 2-bit mode field per pin: 0 is input, 1 is output, and 2 or 3 are special function. A narrow bank has one mode bit per pin, where 0 is output and 1 is special function, and it has no pull-up register. The same block also captures a bank. It reads the live words and presents them on its capture outputs, so that a later restore can replay them.

Top module: `gpio_restore_seq`

## Requirements
- R1: On a standard restore, the first mode write gives the new mode to each pin whose move is input to special (0 to 2/3), output to special (1 to 2/3), output to input (1 to 0) or special to input (2/3 to 0). Every other pin keeps its live mode in that write: unchanged, special to special, input to output, special to output.
- R2: A standard restore issues four writes on consecutive cycles: the mixed mode word at address 0, then the saved data word at address 1, then the full saved mode word at address 0, then the saved pull-up word at address 2.
- R3: Register addresses are 0 for mode, 1 for data and 2 for pull-up. Read data is valid the cycle after a read request. Every operation reads the mode word and then the data word before it issues any write.
- R4: A narrow restore issues three writes: the OR of the live and saved mode words at address 0, then the saved data word at address 1, then the saved mode word at address 0. It never writes address 2.
- R5: A standard capture reads addresses 0, 1 and 2, issues no write, and presents the three words on cap_con, cap_dat and cap_up.
- R6: A narrow capture reads only addresses 0 and 1, updates cap_con and cap_dat, and leaves cap_up unchanged.
- R7: busy is high from the cycle after start until done, inclusive. done is a one-cycle pulse in the cycle after the last access. A standard restore is busy for 8 cycles, a narrow restore for 7, a standard capture for 5 and a narrow capture for 4.
- R8: A start pulse while busy is ignored. The running operation finishes with its own words, and no further operation follows.
- R9: A read and a write are never issued in the same cycle.
- R10: Synchronous active-high reset returns the block to idle: busy, done, rd_req and wr_en all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled while idle |
| capture | input | 1 | 1 selects capture, 0 selects restore |
| narrow | input | 1 | 1 selects the one-bit-per-pin bank type |
| sv_con | input | 2*PINS | Saved mode word |
| sv_dat | input | 2*PINS | Saved data word |
| sv_up | input | 2*PINS | Saved pull-up word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 2 | Read address: 0 mode, 1 data, 2 pull-up |
| rd_data | input | 2*PINS | Read data, valid one cycle after rd_req |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | Write address: 0 mode, 1 data, 2 pull-up |
| wr_data | output | 2*PINS | Write data |
| cap_con | output | 2*PINS | Captured mode word |
| cap_dat | output | 2*PINS | Captured data word |
| cap_up | output | 2*PINS | Captured pull-up word |

## Verification
The assertions assume that the register model answers each read exactly one cycle after the request. They also assume that start is held for a single cycle and that reset is applied before the first start. The bench meets these assumptions with a registered model that always returns data on the next edge. It drives start for exactly one cycle from negedge-aligned tasks. It drives a second start only in the dedicated overlap case, where it checks that the pulse is ignored.

// File: rtl/gpio_restore_seq.sv
module gpio_restore_seq #(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              capture,
  input  logic              narrow,
  input  logic [2*PINS-1:0] sv_con,
  input  logic [2*PINS-1:0] sv_dat,
  input  logic [2*PINS-1:0] sv_up,
  output logic              busy,
  output logic              done,
  output logic              rd_req,
  output logic [1:0]        rd_addr,
  input  logic [2*PINS-1:0] rd_data,
  output logic              wr_en,
  output logic [1:0]        wr_addr,
  output logic [2*PINS-1:0] wr_data,
  output logic [2*PINS-1:0] cap_con,
  output logic [2*PINS-1:0] cap_dat,
  output logic [2*PINS-1:0] cap_up
);
  localparam int W = 2 * PINS;
  localparam logic [1:0] A_CON = 2'd0;
  localparam logic [1:0] A_DAT = 2'd1;
  localparam logic [1:0] A_UP  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RCON, S_RDAT, S_RUP, S_RLAST, S_W1, S_W2, S_W3, S_W4, S_FIN
  } state_t;

  state_t         state;
  logic           cap_q, nar_q;
  logic [W-1:0]   scon, sdat, sup, live_con, early, first_con;
  logic           rd_pend;
  logic [1:0]     rd_addr_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] om, nm;
    assign om = live_con[2*i +: 2];
    assign nm = scon[2*i +: 2];
    assign early[2*i +: 2] = {2{(om != nm) && !(om[1] && nm[1]) && (nm != 2'd1)}};
  end

  assign first_con = nar_q ? (live_con | scon)
                           : ((live_con & ~early) | (scon & early));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cap_q <= 1'b0;
      nar_q <= 1'b0;
      scon  <= '0;
      sdat  <= '0;
      sup   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RCON;
          cap_q <= capture;
          nar_q <= narrow;
          scon  <= sv_con;
          sdat  <= sv_dat;
          sup   <= sv_up;
        end
        S_RCON:  state <= S_RDAT;
        S_RDAT:  state <= (cap_q && !nar_q) ? S_RUP : S_RLAST;
        S_RUP:   state <= S_RLAST;
        S_RLAST: state <= cap_q ? S_FIN : S_W1;
        S_W1:    state <= S_W2;
        S_W2:    state <= S_W3;
        S_W3:    state <= nar_q ? S_FIN : S_W4;
        S_W4:    state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= A_CON;
      live_con  <= '0;
      cap_con   <= '0;
      cap_dat   <= '0;
      cap_up    <= '0;
    end else begin
      rd_pend   <= rd_req;
      rd_addr_q <= rd_addr;
      if (rd_pend) begin
        if (rd_addr_q == A_CON) live_con <= rd_data;
        if (cap_q) begin
          if (rd_addr_q == A_CON) cap_con <= rd_data;
          if (rd_addr_q == A_DAT) cap_dat <= rd_data;
          if (rd_addr_q == A_UP)  cap_up  <= rd_data;
        end
      end
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign rd_req  = (state == S_RCON) || (state == S_RDAT) || (state == S_RUP);
  assign rd_addr = (state == S_RDAT) ? A_DAT : (state == S_RUP) ? A_UP : A_CON;
  assign wr_en   = (state == S_W1) || (state == S_W2) || (state == S_W3) || (state == S_W4);

  always_comb begin
    wr_addr = A_CON;
    wr_data = '0;
    case (state)
      S_W1: begin wr_addr = A_CON; wr_data = first_con; end
      S_W2: begin wr_addr = A_DAT; wr_data = sdat;      end
      S_W3: begin wr_addr = A_CON; wr_data = scon;      end
      S_W4: begin wr_addr = A_UP;  wr_data = sup;       end
      default: ;
    endcase
  end

  assert_single_access_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_en));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_read_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rd_req && rd_addr == A_CON));
  assert_up_last_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_UP) |=> done);
  assert_narrow_no_up_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_req) && nar_q && busy) |-> (wr_addr != A_UP && rd_addr != A_UP));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(scon) && $stable(cap_q)));
  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !wr_en && !rd_req));
endmodule

// File: tb/gpio_restore_seq_tb.sv
module gpio_restore_seq_tb;
  localparam int PINS = 16;
  localparam int W = 2 * PINS;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, capture = 1'b0, narrow = 1'b0;
  logic [W-1:0] sv_con = '0, sv_dat = '0, sv_up = '0;
  logic busy, done, rd_req, wr_en;
  logic [1:0] rd_addr, wr_addr;
  logic [W-1:0] rd_data, wr_data, cap_con, cap_dat, cap_up;

  always #5 clk = ~clk;

  gpio_restore_seq #(.PINS(PINS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .capture(capture), .narrow(narrow),
    .sv_con(sv_con), .sv_dat(sv_dat), .sv_up(sv_up),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_con(cap_con), .cap_dat(cap_dat), .cap_up(cap_up));

  logic [W-1:0] mem [3];
  logic         pre_en = 1'b0;
  logic [W-1:0] pre_con = '0, pre_dat = '0, pre_up = '0;
  logic [1:0]   log_a [256];
  logic [W-1:0] log_d [256];
  int           log_c [256];
  int cyc = 0, wn = 0, rn = 0, rup_n = 0, bcyc = 0, done_cyc = 0, last_rd_cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy) bcyc <= bcyc + 1;
    if (done) done_cyc <= cyc;
    if (rd_req) begin
      rd_data <= mem[rd_addr];
      rn <= rn + 1;
      last_rd_cyc <= cyc;
      if (rd_addr == 2'd2) rup_n <= rup_n + 1;
    end
    if (pre_en) begin
      mem[0] <= pre_con; mem[1] <= pre_dat; mem[2] <= pre_up;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      log_a[wn % 256] <= wr_addr;
      log_d[wn % 256] <= wr_data;
      log_c[wn % 256] <= cyc;
      wn <= wn + 1;
    end
  end

  int checks = 0, errors = 0;
  int wbase, rbase, rubase, bbase, rdbase;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] early_mask(input logic [W-1:0] o, input logic [W-1:0] n);
    logic [W-1:0] m = '0;
    for (int i = 0; i < PINS; i++) begin
      int om = int'(o[2*i +: 2]);
      int nm = int'(n[2*i +: 2]);
      bit take = (om != nm) && !(om >= 2 && nm >= 2) && (nm != 1);
      if (take) m[2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

  task automatic run_op(input bit cap, input bit nar, input logic [W-1:0] c, d, u,
                        input logic [W-1:0] pc, pd, pu);
    @(negedge clk);
    pre_con = pc; pre_dat = pd; pre_up = pu; pre_en = 1'b1;
    @(negedge clk);
    pre_en = 1'b0;
    wbase = wn; rbase = rn; rubase = rup_n; bbase = bcyc;
    start = 1'b1; capture = cap; narrow = nar; sv_con = c; sv_dat = d; sv_up = u;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    chk(done, "R7 done seen", W'(done), W'(1));
    @(negedge clk);
    chk(!busy, "R7 idle after done", W'(busy), W'(0));
  endtask

  task automatic check_restore(input bit nar, input logic [W-1:0] c, d, u, pc);
    logic [W-1:0] first;
    int nw = nar ? 3 : 4;
    first = nar ? (pc | c) : ((pc & ~early_mask(pc, c)) | (c & early_mask(pc, c)));
    chk(wn - wbase == nw, nar ? "R4 write count" : "R2 write count", W'(wn - wbase), W'(nw));
    chk(log_a[wbase % 256] == 2'd0 && log_d[wbase % 256] == first,
        nar ? "R4 first mode write" : "R1 first mode write", log_d[wbase % 256], first);
    chk(log_a[(wbase + 1) % 256] == 2'd1 && log_d[(wbase + 1) % 256] == d,
        "R2 data write", log_d[(wbase + 1) % 256], d);
    chk(log_a[(wbase + 2) % 256] == 2'd0 && log_d[(wbase + 2) % 256] == c,
        "R2 full mode write", log_d[(wbase + 2) % 256], c);
    if (!nar)
      chk(log_a[(wbase + 3) % 256] == 2'd2 && log_d[(wbase + 3) % 256] == u,
          "R2 pull-up write last", log_d[(wbase + 3) % 256], u);
    chk(log_c[(wbase + nw - 1) % 256] - log_c[wbase % 256] == nw - 1,
        "R2 consecutive writes", W'(log_c[(wbase + nw - 1) % 256] - log_c[wbase % 256]), W'(nw - 1));
    chk(done_cyc == log_c[(wbase + nw - 1) % 256] + 1, "R7 done after last write",
        W'(done_cyc), W'(log_c[(wbase + nw - 1) % 256] + 1));
    chk(rn - rbase == 2 && last_rd_cyc < log_c[wbase % 256], "R3 reads before writes",
        W'(rn - rbase), W'(2));
    chk(bcyc - bbase == (nar ? 7 : 8), "R7 busy length", W'(bcyc - bbase), W'(nar ? 7 : 8));
  endtask

  logic [W-1:0] lcg = 32'h1234_5678;
  function automatic logic [W-1:0] nxt(input logic [W-1:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] oc, nc, d, u, sc, sd, su;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !rd_req && !wr_en, "R10 reset idle",
        W'({busy, done, rd_req, wr_en}), W'(0));

    for (int k = 0; k < PINS; k++) begin
      oc = '0; nc = '0;
      for (int i = 0; i < PINS; i++) begin
        int code = (i + k) % 16;
        oc[2*i +: 2] = 2'(code >> 2);
        nc[2*i +: 2] = 2'(code & 3);
      end
      d = {16'(k), 16'hA5A5}; u = ~d;
      run_op(1'b0, 1'b0, nc, d, u, oc, 32'h0F0F_0F0F, 32'h3333_3333);
      check_restore(1'b0, nc, d, u, oc);
    end

    for (int k = 0; k < 10; k++) begin
      lcg = nxt(lcg); oc = lcg; lcg = nxt(lcg); nc = lcg;
      lcg = nxt(lcg); d = lcg; lcg = nxt(lcg); u = lcg;
      run_op(1'b0, 1'b0, nc, d, u, oc, ~d, ~u);
      check_restore(1'b0, nc, d, u, oc);
    end

    for (int k = 0; k < 6; k++) begin
      lcg = nxt(lcg); oc = lcg; lcg = nxt(lcg); nc = lcg; lcg = nxt(lcg); d = lcg;
      run_op(1'b0, 1'b1, nc, d, 32'hDEAD_BEEF, oc, ~d, 32'h1111_2222);
      check_restore(1'b1, nc, d, 32'hDEAD_BEEF, oc);
      chk(mem[2] == 32'h1111_2222, "R4 pull-up untouched", mem[2], 32'h1111_2222);
    end

    for (int k = 0; k < 3; k++) begin
      lcg = nxt(lcg); sc = lcg; lcg = nxt(lcg); sd = lcg; lcg = nxt(lcg); su = lcg;
      run_op(1'b1, 1'b0, '0, '0, '0, sc, sd, su);
      chk(cap_con == sc, "R5 captured mode", cap_con, sc);
      chk(cap_dat == sd, "R5 captured data", cap_dat, sd);
      chk(cap_up == su, "R5 captured pull-up", cap_up, su);
      chk(wn == wbase, "R5 no writes", W'(wn - wbase), W'(0));
      chk(rn - rbase == 3, "R5 three reads", W'(rn - rbase), W'(3));
      chk(bcyc - bbase == 5, "R7 capture busy length", W'(bcyc - bbase), W'(5));
    end

    for (int k = 0; k < 2; k++) begin
      u = cap_up;
      lcg = nxt(lcg); sc = lcg; lcg = nxt(lcg); sd = lcg;
      run_op(1'b1, 1'b1, '0, '0, '0, sc, sd, ~u);
      chk(cap_con == sc && cap_dat == sd, "R6 narrow capture words", cap_dat, sd);
      chk(cap_up == u, "R6 pull-up kept", cap_up, u);
      chk(rup_n == rubase && rn - rbase == 2, "R6 no pull-up read", W'(rup_n - rubase), W'(0));
      chk(bcyc - bbase == 4, "R7 narrow capture busy length", W'(bcyc - bbase), W'(4));
    end

    sc = cap_con;
    @(negedge clk);
    pre_con = 32'h5555_0000; pre_dat = 32'h0; pre_up = 32'h0; pre_en = 1'b1;
    @(negedge clk);
    pre_en = 1'b0;
    wbase = wn; rbase = rn; bbase = bcyc;
    start = 1'b1; capture = 1'b0; narrow = 1'b0;
    sv_con = 32'hAAAA_5555; sv_dat = 32'h1357_9BDF; sv_up = 32'h2468_ACE0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; capture = 1'b1; narrow = 1'b1;
    sv_con = 32'hFFFF_FFFF; sv_dat = 32'h0; sv_up = 32'h0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!busy, "R8 no second operation", W'(busy), W'(0));
    chk(cap_con == sc, "R8 capture not run", cap_con, sc);
    check_restore(1'b0, 32'hAAAA_5555, 32'h1357_9BDF, 32'h2468_ACE0, 32'h5555_0000);

    @(negedge clk);
    start = 1'b1; capture = 1'b0; narrow = 1'b0;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !wr_en && !rd_req && !done, "R10 reset mid-operation",
        W'({busy, done, rd_req, wr_en}), W'(0));
    repeat (3) @(negedge clk);
    chk(!busy && !wr_en, "R10 stays idle", W'({busy, wr_en}), W'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule